// File: doc/BRIEF.md
# Boot-Time Register Table Loader

After reset, when `start` is pulsed, this block reads a table of register initialisation records from a read-only memory through a 16-bit synchronous read port. It turns each record into one 32-bit write on a simple valid/ready write bus. The first halfword of the table is a signature. If the signature is not one of two accepted values, the load stops at once and a not-calibrated flag is raised.

When the signature is good, the block walks records starting at a fixed halfword offset. Each record is three halfwords: a register offset, the low data half, then the high data half. The walk stops at an end marker. After every write the block waits a fixed settle time before it reads the next record. A cap on the record count ends a table that has no end marker. In every case the block reports completion with a one-cycle pulse.

Top module: `bootcfg_loader`

## Requirements
- R1: Halfword 0 of the table equal to 0xA55A or to 0x5AA5 is accepted as a valid signature, and the record walk proceeds with `not_cal` low.
- R2: Any other value in halfword 0 ends the load without issuing a write. `not_cal` goes high and `done` pulses.
- R3: Records begin at halfword `REC_START`. Each record is three halfwords in this order: offset, data bits 15:0, data bits 31:16. `wr_data` is {third, second}.
- R4: `wr_addr` equals `BASE` plus the zero-extended 16-bit offset.
- R5: An offset halfword of 0xFFFF ends the walk with no write for it. `done` is then high for exactly one cycle.
- R6: After each accepted write, the block waits `CLK_MHZ*SETTLE_US` cycles before the next table read. With `wr_ready` held high, consecutive writes are therefore `CLK_MHZ*SETTLE_US + 7` cycles apart.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R8: If `MAX_RECS` records have been written and the next offset is not 0xFFFF, the walk stops without another write, `overrun` goes high and `done` pulses.
- R9: `start` clears `not_cal` and `overrun` when the block is idle. A `start` during a load is ignored.
- R10: After reset, `done`, `wr_valid`, `rom_rd`, `not_cal` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken only when idle) |
| rom_rd | output | 1 | Table read strobe |
| rom_addr | output | ADDR_W | Table halfword address |
| rom_data | input | 16 | Read data, valid one cycle after the strobe |
| wr_addr | output | 32 | Register write address |
| wr_data | output | 32 | Register write data |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted when high with `wr_valid` |
| done | output | 1 | One-cycle end-of-load pulse |
| not_cal | output | 1 | Signature rejected on the last load |
| overrun | output | 1 | Record cap reached without an end marker |

## Verification
The assertions check on every cycle that a stalled write holds its address and data, that every write address lies within the 64 KiB window above the base, that `done` never lasts two cycles, that no write is issued while the signature flag is set, and that no table read or further write follows an accepted write in the very next cycle. Only the bench scenarios can show the things that depend on table contents. These are the record count and order, the exact data packing, where the end marker stops the walk, the cap, the full settle spacing, and that a mid-load start leaves the load unchanged.

// File: rtl/bootcfg_loader.sv
module bootcfg_loader #(
  parameter int          ADDR_W    = 10,
  parameter int          REC_START = 64,
  parameter logic [31:0] BASE      = 32'h1000_0000,
  parameter int          CLK_MHZ   = 100,
  parameter int          SETTLE_US = 100,
  parameter int          MAX_RECS  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [15:0]       rom_data,
  output logic [31:0]       wr_addr,
  output logic [31:0]       wr_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              done,
  output logic              not_cal,
  output logic              overrun
);
  localparam int SETTLE_CYC = (CLK_MHZ * SETTLE_US < 1) ? 1 : CLK_MHZ * SETTLE_US;
  localparam int CW  = $clog2(SETTLE_CYC + 1);
  localparam int RCW = $clog2(MAX_RECS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SIGRQ, S_SIGCK, S_REQ, S_CAP, S_WRITE, S_SETTLE, S_FIN
  } st_t;

  st_t              st;
  logic [ADDR_W-1:0] ptr;
  logic [1:0]       field;
  logic [15:0]      off, lo, hi;
  logic [CW-1:0]    cnt;
  logic [RCW-1:0]   nrec;

  assign rom_rd   = (st == S_SIGRQ) || (st == S_REQ);
  assign rom_addr = ptr;
  assign wr_valid = (st == S_WRITE);
  assign wr_addr  = BASE + {16'h0000, off};
  assign wr_data  = {hi, lo};
  assign done     = (st == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; field <= '0; off <= '0; lo <= '0; hi <= '0;
      cnt <= '0; nrec <= '0; not_cal <= 1'b0; overrun <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_SIGRQ; ptr <= '0; nrec <= '0; field <= '0;
          not_cal <= 1'b0; overrun <= 1'b0;
        end
        S_SIGRQ: st <= S_SIGCK;
        S_SIGCK: begin
          if (rom_data == 16'hA55A || rom_data == 16'h5AA5) begin
            st <= S_REQ; ptr <= ADDR_W'(REC_START);
          end else begin
            st <= S_FIN; not_cal <= 1'b1;
          end
        end
        S_REQ: st <= S_CAP;
        S_CAP: begin
          ptr <= ptr + 1'b1;
          case (field)
            2'd0: begin
              if (rom_data == 16'hFFFF) st <= S_FIN;
              else if (nrec == RCW'(MAX_RECS)) begin
                st <= S_FIN; overrun <= 1'b1;
              end else begin
                off <= rom_data; field <= 2'd1; st <= S_REQ;
              end
            end
            2'd1: begin lo <= rom_data; field <= 2'd2; st <= S_REQ; end
            default: begin hi <= rom_data; field <= 2'd0; st <= S_WRITE; end
          endcase
        end
        S_WRITE: if (wr_ready) begin
          st <= S_SETTLE; cnt <= '0; nrec <= nrec + 1'b1;
        end
        S_SETTLE: begin
          if (cnt == CW'(SETTLE_CYC - 1)) st <= S_REQ;
          else cnt <= cnt + 1'b1;
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: a stalled write holds its request
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R4: every address lies in the window above the base
  p_addr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr - BASE) <= 32'h0000_FFFF);

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: no write while the signature was rejected
  p_no_write_bad_sig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    not_cal |-> !wr_valid);

  // R6: settle begins right after an accepted write
  p_settle_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !rom_rd && !wr_valid);

  // R8: overrun only ever reported together with or after completion, never during a write
  p_overrun_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !wr_valid);
endmodule

// File: tb/test_bootcfg_loader.sv
module test_bootcfg_loader;
  localparam int AW = 6, RS = 3, MHZ = 1, SUS = 4, MR = 4;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam int GAP = MHZ * SUS + 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_ready = 1'b1, stall = 1'b0;
  logic rom_rd, wr_valid, done, not_cal, overrun;
  logic [AW-1:0] rom_addr;
  logic [15:0] rom_data;
  logic [31:0] wr_addr, wr_data;
  logic [15:0] mem [64];
  int checks = 0, fails = 0, cyc = 0;
  int n_wr = 0, n_done = 0;
  logic [31:0] got_a [8], got_d [8];
  int stamp [8];

  always #5 clk = ~clk;

  bootcfg_loader #(.ADDR_W(AW), .REC_START(RS), .BASE(BASE), .CLK_MHZ(MHZ),
                   .SETTLE_US(SUS), .MAX_RECS(MR)) i_bootcfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .rom_rd(rom_rd), .rom_addr(rom_addr),
    .rom_data(rom_data), .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .done(done), .not_cal(not_cal), .overrun(overrun));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rom_rd) rom_data <= mem[rom_addr];
    wr_ready <= stall ? (cyc % 3 == 2) : 1'b1;
  end

  always @(negedge clk) begin
    if (wr_valid && wr_ready) begin
      if (n_wr < 8) begin got_a[n_wr] = wr_addr; got_d[n_wr] = wr_data; stamp[n_wr] = cyc; end
      n_wr = n_wr + 1;
    end
    if (done) n_done = n_done + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] offv(int n, int k);
    return 16'(n * 16'h0040 + k * 4 + 16'h0010);
  endfunction
  function automatic logic [31:0] datv(int n, int k);
    return 32'hC0DE_0000 ^ (32'(n) << 8) ^ (32'(k) * 32'h0001_1111);
  endfunction

  task automatic fill(input logic [15:0] sig, input int n, input bit term);
    for (int i = 0; i < 64; i++) mem[i] = 16'h1234;
    mem[0] = sig;
    for (int k = 0; k < n; k++) begin
      mem[RS + 3*k]     = offv(n, k);
      mem[RS + 3*k + 1] = datv(n, k)[15:0];
      mem[RS + 3*k + 2] = datv(n, k)[31:16];
    end
    if (term) mem[RS + 3*n] = 16'hFFFF;
  endtask

  task automatic run(input bit restart);
    n_wr = 0; n_done = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    for (int t = 0; t < 3000 && n_done == 0; t++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic check_good(input int n, input bit gaps, input string tag);
    chk(n_wr == n, {tag, " R3 R5 write count"}, 32'(n_wr), 32'(n));
    chk(n_done == 1, "R5 one done pulse", 32'(n_done), 32'd1);
    chk(!not_cal, "R1 R9 not_cal low", {31'd0, not_cal}, 32'd0);
    chk(!overrun, "R9 overrun low", {31'd0, overrun}, 32'd0);
    for (int k = 0; k < n && k < 8; k++) begin
      chk(got_a[k] == BASE + {16'h0, offv(n, k)}, "R4 address", got_a[k], BASE + {16'h0, offv(n, k)});
      chk(got_d[k] == datv(n, k), "R3 data packing", got_d[k], datv(n, k));
      if (gaps && k > 0)
        chk(stamp[k] - stamp[k-1] == GAP, "R6 settle spacing", 32'(stamp[k] - stamp[k-1]), 32'(GAP));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] bad [5];
    bad[0] = 16'h0000; bad[1] = 16'hFFFF; bad[2] = 16'hA55B; bad[3] = 16'h5AA4; bad[4] = 16'h5AA5 ^ 16'h8000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !wr_valid && !rom_rd && !not_cal && !overrun, "R10 reset state",
        {27'd0, done, wr_valid, rom_rd, not_cal, overrun}, 32'd0);

    // R1 R3 R4 R5 R6: every length up to the cap, both signatures
    for (int n = 0; n <= MR; n++)
      for (int s = 0; s < 2; s++) begin
        fill(s ? 16'h5AA5 : 16'hA55A, n, 1'b1);
        run(1'b0);
        check_good(n, 1'b1, "R1");
      end

    // R2: rejected signatures
    for (int b = 0; b < 5; b++) begin
      fill(bad[b], 2, 1'b1);
      run(1'b0);
      chk(n_wr == 0, "R2 no writes", 32'(n_wr), 32'd0);
      chk(not_cal, "R2 not_cal set", {31'd0, not_cal}, 32'd1);
      chk(n_done == 1, "R2 done pulse", 32'(n_done), 32'd1);
    end

    // R9: flag cleared by the next load
    fill(16'hA55A, 1, 1'b1);
    run(1'b0);
    check_good(1, 1'b1, "R9");

    // R8: no end marker
    fill(16'h5AA5, MR + 1, 1'b0);
    run(1'b0);
    chk(n_wr == MR, "R8 write count at cap", 32'(n_wr), 32'(MR));
    chk(overrun, "R8 overrun set", {31'd0, overrun}, 32'd1);
    chk(n_done == 1, "R8 done pulse", 32'(n_done), 32'd1);
    for (int k = 0; k < MR; k++)
      chk(got_d[k] == datv(MR + 1, k), "R8 data", got_d[k], datv(MR + 1, k));

    // R7: write stalls
    stall = 1'b1;
    fill(16'hA55A, 3, 1'b1);
    run(1'b0);
    check_good(3, 1'b0, "R7");
    stall = 1'b0;

    // R9: start during a load is ignored
    fill(16'h5AA5, 3, 1'b1);
    run(1'b1);
    check_good(3, 1'b1, "R9 restart");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule